// File: doc/BRIEF.md
# Indexed-Access Register Slave

This block is a control/status register slave that sits behind a simple single-cycle CPU register bus. A master elsewhere in the chip handles the CPU side and the decoding between slaves. This slave sees only a select strobe, a write enable, a local offset and write data. It returns read data in a register one clock after each read.

The slave's register space has two parts. A small group of registers is mapped directly: each sits at its own offset. A separate bank of registers has no offsets of its own and is reached through a window of two directly mapped registers:

- **Index pointer.** Software writes the number of the bank entry it wants into this register.
- **Data port.** Every later read or write of this register acts on the bank entry named by the pointer.

The pointer keeps its value until it is written again. This lets software stream several accesses at one bank entry without rewriting the pointer.

Top module: `idxreg_slave`

## Requirements
- R1: Synchronous active-high reset sets the read data output to zero and the read-valid output low. Reset also sets the index pointer to zero, direct register k to 0xC0DE_0000 + k, and bank entry j to 0x1DA7_0000 + j.
- R2: Offsets 0 to N_DIRECT-1 address the direct registers. A write stores the full 32-bit word, and a later read at that offset returns it.
- R3: `rvalid` is high in exactly the cycle after a read request (`sel`=1, `wr_en`=0) and low otherwise. It stays low after writes. Whenever `rvalid` is low, `rdata` is zero.
- R4: Offset N_DIRECT holds the IDX_W-bit index pointer. A write keeps the low IDX_W bits of the write data, and a read returns the pointer zero-extended. The pointer holds its value until the next write to that offset, so repeated data-port accesses hit the same entry.
- R5: A write at offset N_DIRECT+1 (the data port) stores the write data into the bank entry selected by the index pointer. No other entry changes.
- R6: A read of the data port returns the contents of the bank entry selected by the index pointer.
- R7: When the index pointer is N_INDEXED or above, a data-port read returns zero and a data-port write changes no bank entry.
- R8: Offsets above N_DIRECT+1 are unmapped. Reads there return zero, and writes there change no register.
- R9: With `sel` low, nothing is written, whatever `wr_en`, `offset` and `wdata` hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sel | input | 1 | Request strobe for this slave, one cycle per access |
| wr_en | input | 1 | 1 = write, 0 = read, sampled with `sel` |
| offset | input | 4 | Local register offset |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data, valid one cycle after the read |
| rvalid | output | 1 | High in the cycle `rdata` carries read data |

## Verification
The bench sweeps every offset of the four-bit space. Each direct register gets a distinct per-register word, so a decode that aliases two offsets shows up as the wrong word. Every bank entry is filled through the pointer with its own word and then read back in a separate sweep; this separates a pointer that fails to select from one that selects the wrong entry. Out-of-range pointer values, including the all-ones value, and unmapped offsets are written with all-ones data, after which every mapped register is re-read to prove that nothing moved. Pointer truncation, repeated accesses under one pointer value, idle cycles with `sel` low, and a second reset in mid-run complete the patterns.

// File: rtl/idxreg_pkg.sv
package idxreg_pkg;

    localparam int DATA_W = 32;
    localparam int OFFS_W = 4;

    typedef enum logic [1:0] {
        ACC_NONE     = 2'd0,
        ACC_DIRECT   = 2'd1,
        ACC_IDX_PTR  = 2'd2,
        ACC_IDX_PORT = 2'd3
    } acc_kind_e;

    typedef struct packed {
        acc_kind_e kind;
        logic      rd;
        logic      wr;
    } dec_t;

    function automatic logic [DATA_W-1:0] dir_rst_val(int k);
        return DATA_W'(32'hC0DE_0000 + k);
    endfunction

    function automatic logic [DATA_W-1:0] bank_rst_val(int j);
        return DATA_W'(32'h1DA7_0000 + j);
    endfunction

endpackage

// File: rtl/idxreg_decode.sv
module idxreg_decode
    import idxreg_pkg::*;
#(
    parameter int N_DIRECT = 4
) (
    input  logic              sel,
    input  logic              wr_en,
    input  logic [OFFS_W-1:0] offset,
    output dec_t              dec
);

    localparam logic [OFFS_W-1:0] PTR_OFFS  = OFFS_W'(N_DIRECT);
    localparam logic [OFFS_W-1:0] PORT_OFFS = OFFS_W'(N_DIRECT + 1);

    always_comb begin
        dec.rd = sel && !wr_en;
        dec.wr = sel && wr_en;
        if (!sel) begin
            dec.kind = ACC_NONE;
        end else if (offset < PTR_OFFS) begin
            dec.kind = ACC_DIRECT;
        end else if (offset == PTR_OFFS) begin
            dec.kind = ACC_IDX_PTR;
        end else if (offset == PORT_OFFS) begin
            dec.kind = ACC_IDX_PORT;
        end else begin
            dec.kind = ACC_NONE;
        end
    end

endmodule

// File: rtl/idxreg_direct_bank.sv
module idxreg_direct_bank
    import idxreg_pkg::*;
#(
    parameter int N_DIRECT = 4,
    parameter int DSEL_W   = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [DSEL_W-1:0] dsel,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rd_val
);

    logic [DATA_W-1:0] regs_q [N_DIRECT];

    for (genvar k = 0; k < N_DIRECT; k++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                regs_q[k] <= dir_rst_val(k);
            end else if (we && dsel == DSEL_W'(k)) begin
                regs_q[k] <= wdata;
            end
        end
    end

    always_comb begin
        rd_val = '0;
        for (int k = 0; k < N_DIRECT; k++) begin
            if (dsel == DSEL_W'(k)) begin
                rd_val = regs_q[k];
            end
        end
    end

endmodule

// File: rtl/idxreg_index_bank.sv
module idxreg_index_bank
    import idxreg_pkg::*;
#(
    parameter int N_INDEXED = 8,
    parameter int IDX_W     = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ptr_we,
    input  logic              port_we,
    input  logic [DATA_W-1:0] wdata,
    output logic [IDX_W-1:0]  idx_q,
    output logic [DATA_W-1:0] port_val
);

    localparam int SEL_W = (N_INDEXED > 1) ? $clog2(N_INDEXED) : 1;

    logic [DATA_W-1:0] bank_q [N_INDEXED];
    logic              in_range;
    logic [SEL_W-1:0]  entry;

    assign in_range = (idx_q < IDX_W'(N_INDEXED));
    assign entry    = idx_q[SEL_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q <= '0;
        end else if (ptr_we) begin
            idx_q <= wdata[IDX_W-1:0];
        end
    end

    for (genvar j = 0; j < N_INDEXED; j++) begin : g_ent
        always_ff @(posedge clk) begin
            if (rst) begin
                bank_q[j] <= bank_rst_val(j);
            end else if (port_we && in_range && entry == SEL_W'(j)) begin
                bank_q[j] <= wdata;
            end
        end
    end

    always_comb begin
        port_val = '0;
        for (int j = 0; j < N_INDEXED; j++) begin
            if (in_range && entry == SEL_W'(j)) begin
                port_val = bank_q[j];
            end
        end
    end

endmodule

// File: rtl/idxreg_slave.sv
module idxreg_slave
    import idxreg_pkg::*;
#(
    parameter int N_DIRECT  = 4,
    parameter int N_INDEXED = 8,
    parameter int IDX_W     = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sel,
    input  logic              wr_en,
    input  logic [OFFS_W-1:0] offset,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid
);

    localparam int DSEL_W = (N_DIRECT > 1) ? $clog2(N_DIRECT) : 1;

    dec_t              dec;
    logic [DATA_W-1:0] dir_val;
    logic [DATA_W-1:0] port_val;
    logic [IDX_W-1:0]  idx_q;
    logic [DATA_W-1:0] rd_mux;

    idxreg_decode #(
        .N_DIRECT(N_DIRECT)
    ) u_dec (
        .sel    (sel),
        .wr_en  (wr_en),
        .offset (offset),
        .dec    (dec)
    );

    idxreg_direct_bank #(
        .N_DIRECT(N_DIRECT),
        .DSEL_W  (DSEL_W)
    ) u_dir (
        .clk    (clk),
        .rst    (rst),
        .we     (dec.wr && dec.kind == ACC_DIRECT),
        .dsel   (offset[DSEL_W-1:0]),
        .wdata  (wdata),
        .rd_val (dir_val)
    );

    idxreg_index_bank #(
        .N_INDEXED(N_INDEXED),
        .IDX_W    (IDX_W)
    ) u_bank (
        .clk      (clk),
        .rst      (rst),
        .ptr_we   (dec.wr && dec.kind == ACC_IDX_PTR),
        .port_we  (dec.wr && dec.kind == ACC_IDX_PORT),
        .wdata    (wdata),
        .idx_q    (idx_q),
        .port_val (port_val)
    );

    always_comb begin
        unique case (dec.kind)
            ACC_DIRECT:   rd_mux = dir_val;
            ACC_IDX_PTR:  rd_mux = DATA_W'(idx_q);
            ACC_IDX_PORT: rd_mux = port_val;
            default:      rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata  <= '0;
            rvalid <= 1'b0;
        end else begin
            rvalid <= dec.rd;
            rdata  <= dec.rd ? rd_mux : '0;
        end
    end

endmodule

// File: rtl/idxreg_checker.sv
module idxreg_checker
    import idxreg_pkg::*;
#(
    parameter int N_DIRECT  = 4,
    parameter int N_INDEXED = 8,
    parameter int IDX_W     = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              sel,
    input logic              wr_en,
    input logic [OFFS_W-1:0] offset,
    input logic [DATA_W-1:0] rdata,
    input logic              rvalid,
    input logic [IDX_W-1:0]  idx_q
);

    localparam logic [OFFS_W-1:0] PTR_OFFS  = OFFS_W'(N_DIRECT);
    localparam logic [OFFS_W-1:0] PORT_OFFS = OFFS_W'(N_DIRECT + 1);

    AST_READ_GIVES_VALID: assert property (@(posedge clk) disable iff (rst)
        (sel && !wr_en) |=> rvalid); // R3

    AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (rst)
        !(sel && !wr_en) |=> !rvalid); // R3

    AST_IDLE_DATA_ZERO: assert property (@(posedge clk) disable iff (rst)
        !rvalid |-> (rdata == '0)); // R3

    AST_PTR_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !(sel && wr_en && offset == PTR_OFFS) |=> $stable(idx_q)); // R4

    AST_OOR_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
        (sel && !wr_en && offset == PORT_OFFS && idx_q >= IDX_W'(N_INDEXED))
        |=> (rdata == '0)); // R7

    AST_UNMAPPED_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
        (sel && !wr_en && offset > PORT_OFFS) |=> (rdata == '0)); // R8

endmodule

bind idxreg_slave idxreg_checker #(
    .N_DIRECT (N_DIRECT),
    .N_INDEXED(N_INDEXED),
    .IDX_W    (IDX_W)
) u_chk (
    .clk    (clk),
    .rst    (rst),
    .sel    (sel),
    .wr_en  (wr_en),
    .offset (offset),
    .rdata  (rdata),
    .rvalid (rvalid),
    .idx_q  (idx_q)
);

// File: tb/idxreg_slave_tb_top.sv
module idxreg_slave_tb_top;

    localparam int ND   = 4;
    localparam int NI   = 8;
    localparam int IW   = 8;
    localparam int PTR  = ND;
    localparam int PORT = ND + 1;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sel = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  offset = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        rvalid;

    int n_chk  = 0;
    int n_fail = 0;

    logic [31:0] exp_dir [ND];
    logic [31:0] exp_bank [NI];
    logic [31:0] exp_ptr;

    always #10 clk = ~clk;

    idxreg_slave #(.N_DIRECT(ND), .N_INDEXED(NI), .IDX_W(IW)) dut_i (
        .clk(clk), .rst(rst), .sel(sel), .wr_en(wr_en),
        .offset(offset), .wdata(wdata), .rdata(rdata), .rvalid(rvalid)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %08h expected %08h", req, got, exp);
        end
    endtask

    task automatic bus_write(input int off, input logic [31:0] d);
        sel = 1'b1; wr_en = 1'b1; offset = 4'(off); wdata = d;
        @(negedge clk);
        check("R3 no valid after write", {31'b0, rvalid}, 32'd0);
        sel = 1'b0; wr_en = 1'b0;
    endtask

    task automatic bus_read(input string req, input int off, input logic [31:0] exp);
        sel = 1'b1; wr_en = 1'b0; offset = 4'(off);
        @(negedge clk);
        check({req, " (R3 valid)"}, {31'b0, rvalid}, 32'd1);
        check(req, rdata, exp);
        sel = 1'b0;
        @(negedge clk);
        check("R3 valid drops", {31'b0, rvalid}, 32'd0);
        check("R3 idle data zero", rdata, 32'd0);
    endtask

    task automatic model_reset();
        for (int k = 0; k < ND; k++) exp_dir[k] = 32'hC0DE_0000 + k;
        for (int j = 0; j < NI; j++) exp_bank[j] = 32'h1DA7_0000 + j;
        exp_ptr = 0;
    endtask

    task automatic sweep_all(input string req);
        for (int k = 0; k < ND; k++) bus_read({req, " direct"}, k, exp_dir[k]);
        for (int j = 0; j < NI; j++) begin
            bus_write(PTR, j);
            bus_read({req, " bank"}, PORT, exp_bank[j]);
        end
        exp_ptr = NI - 1;
    endtask

    task automatic do_reset();
        rst = 1'b1; sel = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 reset rdata", rdata, 32'd0);
        check("R1 reset rvalid", {31'b0, rvalid}, 32'd0);
        rst = 1'b0;
        model_reset();
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        @(negedge clk);
        do_reset();

        // R1: reset values of everything reachable
        bus_read("R1 ptr reset", PTR, 32'd0);
        sweep_all("R1 reset value");

        // R2: every direct register with its own word
        for (int k = 0; k < ND; k++) begin
            exp_dir[k] = 32'h5A5A_0000 ^ (32'h0101_0101 * (k + 1));
            bus_write(k, exp_dir[k]);
        end
        for (int k = 0; k < ND; k++) bus_read("R2 direct readback", k, exp_dir[k]);

        // R4: pointer truncation and hold across repeated accesses
        bus_write(PTR, 32'hFFFF_FF03);
        bus_read("R4 ptr truncated", PTR, 32'h0000_0003);
        bus_write(PORT, 32'h1111_1111);
        bus_write(PORT, 32'h2222_2222);
        exp_bank[3] = 32'h2222_2222;
        bus_read("R4 ptr held read1", PORT, 32'h2222_2222);
        bus_read("R4 ptr held read2", PORT, 32'h2222_2222);
        bus_read("R4 ptr still 3", PTR, 32'h0000_0003);

        // R5/R6: fill every entry, then read back in a second pass
        for (int j = 0; j < NI; j++) begin
            exp_bank[j] = 32'hB000_0000 | (32'h0001_0001 * (j + 7));
            bus_write(PTR, j);
            bus_write(PORT, exp_bank[j]);
        end
        for (int j = NI - 1; j >= 0; j--) begin
            bus_write(PTR, j);
            bus_read("R6 bank readback", PORT, exp_bank[j]);
        end
        sweep_all("R5 bank contents");

        // R7: out-of-range pointer values
        for (int p = NI; p < NI + 4; p++) begin
            bus_write(PTR, p);
            bus_write(PORT, 32'hFFFF_FFFF);
            bus_read("R7 oor read zero", PORT, 32'd0);
        end
        bus_write(PTR, 255);
        bus_write(PORT, 32'hFFFF_FFFF);
        bus_read("R7 oor ptr 255 read zero", PORT, 32'd0);
        bus_read("R7 ptr 255 readback", PTR, 32'd255);
        sweep_all("R7 no bank change");

        // R8: unmapped offsets
        for (int o = PORT + 1; o < 16; o++) begin
            bus_write(o, 32'hFFFF_FFFF);
            bus_read("R8 unmapped read zero", o, 32'd0);
        end
        bus_read("R8 ptr unchanged", PTR, exp_ptr);
        sweep_all("R8 no change");

        // R9: writes with sel low do nothing
        for (int o = 0; o < 16; o++) begin
            sel = 1'b0; wr_en = 1'b1; offset = 4'(o); wdata = 32'hDEAD_BEEF;
            @(negedge clk);
            check("R9 idle no valid", {31'b0, rvalid}, 32'd0);
        end
        wr_en = 1'b0;
        bus_read("R9 ptr unchanged", PTR, exp_ptr);
        sweep_all("R9 no change");

        // R1: reset in mid-run restores defaults
        do_reset();
        bus_read("R1 ptr after rerun reset", PTR, 32'd0);
        sweep_all("R1 mid-run reset");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule